// File: doc/BRIEF.md
# Serial Clock-Chip Access Sequencer

This block is the host-side engine that talks to a real-time-clock chip over a chip-selected serial link with a clock, a data-out line and a data-in line. A user request selects one of three jobs: fetch the 32-bit time counter, load a new 32-bit time value, or stream out the battery-backed SRAM image byte by byte. Every job runs inside a single select window. The select line goes low, a fixed 32-bit command word is shifted out most significant bit first, the data phase runs, and the select line goes high again.

The serial link is shared with other agents. A `grant` input stands in for the channel arbiter and is sampled at the moment a request is taken. When the channel is not granted the block does not wait. A time-load request is refused with an error pulse and no transfer. A time fetch is answered at once with a zero value. An SRAM fetch is refused with an error. The serial clock half period and the SRAM image length are parameters.

Top module: `rtc_link_seq`

## Requirements
- R1: `op`=2'b00 (time fetch) sends command word 0x20000000, then clocks in 32 bits, MSB first. The assembled word appears on `rdata` with a one-cycle `rvalid` pulse.
- R2: `op`=2'b01 (time load) sends command word 0x A0000000 written as 0xA0000000, then the 32-bit `wdata` captured at acceptance, MSB first, in the same select window. No `rvalid` pulse follows.
- R3: `op`=2'b10 (SRAM fetch) sends command word 0x20000100, then receives SRAM_BYTES bytes, MSB first. Each byte is delivered on `rdata[7:0]` with `rdata[31:8]`=0 and its own `rvalid` pulse, in arrival order.
- R4: Each accepted operation opens exactly one select window. `cs_n` is low before the first serial clock rise and is high again after the last fall. While the block is idle, `cs_n` is high.
- R5: `sclk` is low whenever `cs_n` is high. Each high phase of `sclk` lasts DIV_HALF clock cycles. `mosi` changes only while `sclk` is low, and `miso` is captured on the rising edge.
- R6: A time load requested while `grant` is low produces a one-cycle `err` pulse in the cycle after the request. It performs no transfer and leaves the device time untouched.
- R7: A time fetch requested while `grant` is low produces, in the cycle after the request, `rvalid` and `err` together with `rdata`=0, and performs no transfer.
- R8: An SRAM fetch requested while `grant` is low produces a one-cycle `err` pulse, with no transfer and no byte output.
- R9: `busy` rises in the cycle after acceptance and falls one cycle after `cs_n` returns high. A request made while `busy` is high is ignored.
- R10: For a granted time fetch, `rvalid` is high 128*DIV_HALF+4 cycles after the accepting edge. The first SRAM byte arrives 80*DIV_HALF+4 cycles after it.
- R11: After reset, `cs_n`=1, `sclk`=0, `busy`=0, `rvalid`=0 and `err`=0.
- R12: `op`=2'b11 is ignored. It produces no busy, no select and no output pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request strobe, one cycle |
| op | input | 2 | Job code: 00 time fetch, 01 time load, 10 SRAM fetch, 11 none |
| wdata | input | 32 | New time value for a time load |
| grant | input | 1 | Shared channel available |
| rdata | output | 32 | Fetched time word or SRAM byte |
| rvalid | output | 1 | `rdata` valid, one-cycle pulse |
| busy | output | 1 | Job in progress |
| err | output | 1 | Request refused, one-cycle pulse |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Device select, active low |
| mosi | output | 1 | Serial data to device |
| miso | input | 1 | Serial data from device |

## Verification
Refusals are registered on the accepting edge, so their `err` and `rvalid` pulses appear one cycle after the request. A granted time fetch answers 128*DIV_HALF+4 cycles after acceptance, and the first SRAM byte answers 80*DIV_HALF+4 cycles after it. The scoreboard holds each expected item with its due latency. A monitor samples on the falling clock edge, counts cycles from the acceptance edge, and compares both the value and the arrival cycle. A bench device model decodes each command word from the serial pins, counts select windows and clock rises per window, and checks the `sclk` high-phase length and the stability of `mosi` at every cycle.

// File: rtl/rtc_link_pkg.sv
package rtc_link_pkg;

  typedef enum logic [1:0] {
    OP_TIME_RD = 2'b00,
    OP_TIME_WR = 2'b01,
    OP_SRAM_RD = 2'b10,
    OP_NONE    = 2'b11
  } op_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CMD,
    ST_DATA,
    ST_REL
  } seq_st_e;

  localparam logic [31:0] CMD_TIME_RD = 32'h2000_0000;
  localparam logic [31:0] CMD_TIME_WR = 32'hA000_0000;
  localparam logic [31:0] CMD_SRAM_RD = 32'h2000_0100;

  function automatic logic [31:0] cmd_of(input op_e o);
    case (o)
      OP_TIME_WR: cmd_of = CMD_TIME_WR;
      OP_SRAM_RD: cmd_of = CMD_SRAM_RD;
      default:    cmd_of = CMD_TIME_RD;
    endcase
  endfunction

endpackage

// File: rtl/rtc_link_shifter.sv
module rtc_link_shifter #(
  parameter int DIV_HALF = 4
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        start,
  input  logic [31:0] word,
  input  logic        short_len,
  input  logic        miso,
  output logic        sclk,
  output logic        mosi,
  output logic [31:0] rx,
  output logic        done
);
  localparam int DW = (DIV_HALF > 1) ? $clog2(DIV_HALF) : 1;
  localparam logic [DW-1:0] DIV_LAST = DW'(DIV_HALF - 1);

  logic [31:0]   tx;
  logic [DW-1:0] div_cnt;
  logic [4:0]    bit_cnt;
  logic          active;
  logic          last_bit;

  assign last_bit = short_len ? (bit_cnt == 5'd7) : (bit_cnt == 5'd31);
  assign mosi     = tx[31];

  always_ff @(posedge clk) begin
    if (rst) begin
      tx      <= '0;
      div_cnt <= '0;
      bit_cnt <= '0;
      active  <= 1'b0;
      sclk    <= 1'b0;
      rx      <= '0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (start) begin
        tx      <= word;
        div_cnt <= '0;
        bit_cnt <= '0;
        active  <= 1'b1;
        sclk    <= 1'b0;
      end else if (active) begin
        if (div_cnt == DIV_LAST) begin
          div_cnt <= '0;
          if (!sclk) begin
            sclk <= 1'b1;
            rx   <= {rx[30:0], miso};
          end else begin
            sclk <= 1'b0;
            tx   <= {tx[30:0], 1'b0};
            if (last_bit) begin
              active <= 1'b0;
              done   <= 1'b1;
            end else begin
              bit_cnt <= bit_cnt + 5'd1;
            end
          end
        end else begin
          div_cnt <= div_cnt + DW'(1);
        end
      end
    end
  end

  // R5: the data line holds while the serial clock is high
  p_mosi_hold_r5: assert property (@(posedge clk) disable iff (rst)
    sclk |-> $stable(mosi));

  // R5: one bit is finished only after a completed high phase
  p_done_after_fall_r5: assert property (@(posedge clk) disable iff (rst)
    done |-> !sclk && $past(sclk));

endmodule

// File: rtl/rtc_link_ctrl.sv
module rtc_link_ctrl
  import rtc_link_pkg::*;
#(
  parameter int SRAM_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic [1:0]  op,
  input  logic [31:0] wdata,
  input  logic        grant,
  input  logic        sh_done,
  input  logic [31:0] sh_rx,
  output logic        sh_start,
  output logic [31:0] sh_word,
  output logic        sh_short,
  output logic [31:0] rdata,
  output logic        rvalid,
  output logic        busy,
  output logic        err,
  output logic        cs_n
);
  localparam int BW = (SRAM_BYTES > 1) ? $clog2(SRAM_BYTES) : 1;
  localparam logic [BW-1:0] BYTE_LAST = BW'(SRAM_BYTES - 1);

  seq_st_e       st;
  op_e           op_q;
  op_e           op_in;
  logic [31:0]   wdata_q;
  logic [BW-1:0] byte_cnt;

  assign op_in = op_e'(op);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      op_q     <= OP_NONE;
      wdata_q  <= '0;
      byte_cnt <= '0;
      sh_start <= 1'b0;
      sh_word  <= '0;
      sh_short <= 1'b0;
      rdata    <= '0;
      rvalid   <= 1'b0;
      busy     <= 1'b0;
      err      <= 1'b0;
      cs_n     <= 1'b1;
    end else begin
      sh_start <= 1'b0;
      rvalid   <= 1'b0;
      err      <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req && op_in != OP_NONE) begin
            if (grant) begin
              st       <= ST_CMD;
              busy     <= 1'b1;
              cs_n     <= 1'b0;
              sh_start <= 1'b1;
              sh_word  <= cmd_of(op_in);
              sh_short <= 1'b0;
              op_q     <= op_in;
              wdata_q  <= wdata;
              byte_cnt <= '0;
            end else begin
              err <= 1'b1;
              if (op_in == OP_TIME_RD) begin
                rvalid <= 1'b1;
                rdata  <= '0;
              end
            end
          end
        end
        ST_CMD: begin
          if (sh_done) begin
            st       <= ST_DATA;
            sh_start <= 1'b1;
            sh_word  <= (op_q == OP_TIME_WR) ? wdata_q : '0;
            sh_short <= (op_q == OP_SRAM_RD);
          end
        end
        ST_DATA: begin
          if (sh_done) begin
            case (op_q)
              OP_SRAM_RD: begin
                rdata  <= {24'd0, sh_rx[7:0]};
                rvalid <= 1'b1;
                if (byte_cnt == BYTE_LAST) begin
                  cs_n <= 1'b1;
                  st   <= ST_REL;
                end else begin
                  byte_cnt <= byte_cnt + BW'(1);
                  sh_start <= 1'b1;
                  sh_word  <= '0;
                  sh_short <= 1'b1;
                end
              end
              OP_TIME_RD: begin
                rdata  <= sh_rx;
                rvalid <= 1'b1;
                cs_n   <= 1'b1;
                st     <= ST_REL;
              end
              default: begin
                cs_n <= 1'b1;
                st   <= ST_REL;
              end
            endcase
          end
        end
        default: begin
          st   <= ST_IDLE;
          busy <= 1'b0;
        end
      endcase
    end
  end

  // R4: no select while idle
  p_idle_deselect_r4: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cs_n);

  // R6: a refused request opens no window and does not go busy
  p_refuse_no_select_r6: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && req && !grant) |=> cs_n && !busy);

  // R7: a refused fetch reports zero
  p_refused_zero_r7: assert property (@(posedge clk) disable iff (rst)
    (rvalid && err) |-> rdata == 32'd0);

  // R9: busy holds while the device is selected
  p_busy_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && !cs_n) |=> busy);

  // R9: a request while busy starts nothing new
  p_ignore_busy_r9: assert property (@(posedge clk) disable iff (rst)
    (busy && req && st == ST_REL) |=> !busy && cs_n);

  // R12: the spare code has no effect
  p_none_ignored_r12: assert property (@(posedge clk) disable iff (rst)
    (st == ST_IDLE && req && op_in == OP_NONE) |=> !busy && !err && !rvalid);

endmodule

// File: rtl/rtc_link_seq.sv
module rtc_link_seq #(
  parameter int DIV_HALF   = 4,
  parameter int SRAM_BYTES = 64
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        req,
  input  logic [1:0]  op,
  input  logic [31:0] wdata,
  input  logic        grant,
  output logic [31:0] rdata,
  output logic        rvalid,
  output logic        busy,
  output logic        err,
  output logic        sclk,
  output logic        cs_n,
  output logic        mosi,
  input  logic        miso
);
  logic        sh_start;
  logic [31:0] sh_word;
  logic        sh_short;
  logic        sh_done;
  logic [31:0] sh_rx;

  rtc_link_ctrl #(.SRAM_BYTES(SRAM_BYTES)) u_ctrl (
    .clk(clk), .rst(rst), .req(req), .op(op), .wdata(wdata), .grant(grant),
    .sh_done(sh_done), .sh_rx(sh_rx), .sh_start(sh_start), .sh_word(sh_word),
    .sh_short(sh_short), .rdata(rdata), .rvalid(rvalid), .busy(busy),
    .err(err), .cs_n(cs_n)
  );

  rtc_link_shifter #(.DIV_HALF(DIV_HALF)) u_shift (
    .clk(clk), .rst(rst), .start(sh_start), .word(sh_word),
    .short_len(sh_short), .miso(miso), .sclk(sclk), .mosi(mosi),
    .rx(sh_rx), .done(sh_done)
  );

  // R5: the serial clock rests low outside a select window
  p_sclk_idle_low_r5: assert property (@(posedge clk) disable iff (rst)
    cs_n |-> !sclk);

  // R4: select is released only with the serial clock low
  p_release_clean_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n) |-> !sclk && !$past(sclk));

endmodule

// File: tb/tb_rtc_link_seq.sv
module tb_rtc_link_seq;
  localparam int DIV   = 4;
  localparam int BYTES = 64;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        req = 1'b0;
  logic [1:0]  op = 2'b00;
  logic [31:0] wdata = '0;
  logic        grant = 1'b1;
  logic [31:0] rdata;
  logic        rvalid, busy, err, sclk, cs_n, mosi;
  logic        miso = 1'b0;

  always #2.5 clk = ~clk;

  rtc_link_seq #(.DIV_HALF(DIV), .SRAM_BYTES(BYTES)) dut (
    .clk(clk), .rst(rst), .req(req), .op(op), .wdata(wdata), .grant(grant),
    .rdata(rdata), .rvalid(rvalid), .busy(busy), .err(err), .sclk(sclk),
    .cs_n(cs_n), .mosi(mosi), .miso(miso)
  );

  int total = 0;
  int bad = 0;
  int cyc = 0;
  int t_acc = 0;
  bit finished = 0;

  typedef struct {
    bit          rv;
    bit          er;
    logic [31:0] d;
    int          lat;
    string       tag;
  } exp_t;
  exp_t q[$];

  task automatic check(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, expv);
    end
  endtask

  always @(posedge clk) cyc++;

  // device model
  logic [31:0] dev_time = 32'h1234_5678;
  logic [31:0] dev_sh = '0;
  logic [31:0] dev_cmd = '0;
  int dev_bits = 0;
  int last_bits = 0;
  int windows = 0;

  function automatic logic [7:0] sram_byte(input int k);
    logic [7:0] kb;
    kb = k[7:0];
    return 8'h3C ^ (kb * 8'd7);
  endfunction

  always @(negedge cs_n) begin
    dev_bits = 0;
    windows++;
  end

  always @(posedge cs_n) begin
    last_bits = dev_bits;
    if (dev_bits == 64 && dev_cmd == 32'hA000_0000) dev_time = dev_sh;
  end

  always @(posedge sclk) begin
    if (!cs_n) begin
      dev_sh = {dev_sh[30:0], mosi};
      dev_bits++;
      if (dev_bits == 32) dev_cmd = dev_sh;
    end
  end

  always @(negedge sclk) begin
    if (!cs_n && dev_bits >= 32) begin
      int k;
      k = dev_bits - 32;
      if (dev_cmd == 32'h2000_0000 && k < 32) miso = dev_time[31-k];
      else if (dev_cmd == 32'h2000_0100 && k < 8*BYTES) miso = sram_byte(k/8)[7-(k%8)];
    end
  end

  // R5 line checks: high phase length and data stability
  int hi_len = 0;
  logic mosi_prev = 1'b0;
  logic sclk_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (sclk && sclk_prev && mosi !== mosi_prev)
        check(1'b0, "R5 mosi moved while sclk high", 32'(mosi), 32'(mosi_prev));
      if (sclk) hi_len++;
      if (!sclk && sclk_prev) begin
        check(hi_len == DIV, "R5 sclk high phase", 32'(hi_len), 32'(DIV));
        hi_len = 0;
      end
      if (cs_n && sclk) check(1'b0, "R5 sclk high while deselected", 1, 0);
    end
    mosi_prev = mosi;
    sclk_prev = sclk;
  end

  // monitor
  always @(negedge clk) begin
    if (!rst && (rvalid || err)) begin
      if (q.size() == 0) begin
        check(1'b0, "unexpected output", {30'd0, rvalid, err}, 0);
      end else begin
        exp_t e;
        e = q.pop_front();
        check(rvalid == e.rv && err == e.er, {e.tag, " flags"},
              {30'd0, rvalid, err}, {30'd0, e.rv, e.er});
        if (e.rv) check(rdata == e.d, {e.tag, " data"}, rdata, e.d);
        if (e.lat >= 0)
          check(cyc - t_acc == e.lat, {e.tag, " latency"}, 32'(cyc - t_acc), 32'(e.lat));
      end
    end
  end

  task automatic push(input bit rv, input bit er, input logic [31:0] d,
                      input int lat, input string tag);
    exp_t e;
    e.rv = rv; e.er = er; e.d = d; e.lat = lat; e.tag = tag;
    q.push_back(e);
  endtask

  task automatic issue(input logic [1:0] o, input logic [31:0] wd, input bit g);
    @(negedge clk);
    req = 1'b1; op = o; wdata = wd; grant = g;
    @(negedge clk);
    t_acc = cyc;
    req = 1'b0; grant = 1'b1;
  endtask

  task automatic settle();
    while (busy) @(negedge clk);
    repeat (4) @(negedge clk);
    check(q.size() == 0, "scoreboard drained", 32'(q.size()), 0);
  endtask

  initial begin
    int w0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check({cs_n, sclk, busy, rvalid, err} == 5'b10000, "R11 reset state",
          {27'd0, cs_n, sclk, busy, rvalid, err}, 32'h10);

    // R1 / R10 time fetch
    w0 = windows;
    push(1, 0, 32'h1234_5678, 128*DIV+4, "R1 R10 time fetch");
    issue(2'b00, '0, 1);
    check(busy == 1'b1, "R9 busy after accept", 32'(busy), 1);
    settle();
    check(dev_cmd == 32'h2000_0000, "R1 command word", dev_cmd, 32'h2000_0000);
    check(windows == w0 + 1, "R4 one window", 32'(windows), 32'(w0 + 1));
    check(last_bits == 64, "R4 bits in window", 32'(last_bits), 64);

    // R2 time load
    w0 = windows;
    issue(2'b01, 32'hCAFE_F00D, 1);
    settle();
    check(dev_cmd == 32'hA000_0000, "R2 command word", dev_cmd, 32'hA000_0000);
    check(dev_time == 32'hCAFE_F00D, "R2 value written", dev_time, 32'hCAFE_F00D);
    check(windows == w0 + 1 && last_bits == 64, "R4 load window",
          32'(last_bits), 64);

    push(1, 0, 32'hCAFE_F00D, 128*DIV+4, "R1 fetch after load");
    issue(2'b00, '0, 1);
    settle();

    // R3 SRAM fetch
    w0 = windows;
    for (int k = 0; k < BYTES; k++)
      push(1, 0, {24'd0, sram_byte(k)}, (k == 0) ? 80*DIV+4 : -1, "R3 R10 sram byte");
    issue(2'b10, '0, 1);
    settle();
    check(dev_cmd == 32'h2000_0100, "R3 command word", dev_cmd, 32'h2000_0100);
    check(windows == w0 + 1 && last_bits == 32 + 8*BYTES, "R4 sram window",
          32'(last_bits), 32'(32 + 8*BYTES));

    // refusals
    w0 = windows;
    push(0, 1, '0, 0, "R6 refused load");
    issue(2'b01, 32'h0BAD_0BAD, 0);
    settle();
    check(dev_time == 32'hCAFE_F00D, "R6 time untouched", dev_time, 32'hCAFE_F00D);
    push(1, 1, '0, 0, "R7 refused fetch");
    issue(2'b00, '0, 0);
    settle();
    push(0, 1, '0, 0, "R8 refused sram");
    issue(2'b10, '0, 0);
    settle();
    check(windows == w0, "R6 R7 R8 no window", 32'(windows), 32'(w0));

    // R9 request while busy is ignored
    w0 = windows;
    push(1, 0, 32'hCAFE_F00D, 128*DIV+4, "R9 fetch with busy request");
    issue(2'b00, '0, 1);
    repeat (20) @(negedge clk);
    req = 1'b1; op = 2'b01; wdata = 32'h5555_AAAA;
    @(negedge clk);
    req = 1'b0;
    settle();
    check(windows == w0 + 1, "R9 single window", 32'(windows), 32'(w0 + 1));
    check(dev_time == 32'hCAFE_F00D, "R9 load ignored", dev_time, 32'hCAFE_F00D);

    // R12 spare code
    w0 = windows;
    issue(2'b11, '0, 1);
    check(busy == 1'b0, "R12 no busy", 32'(busy), 0);
    settle();
    check(windows == w0, "R12 no window", 32'(windows), 32'(w0));

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    if (!finished) begin
      check(1'b0, "watchdog", 32'(cyc), 0);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule